// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block collects eight 32-bit elements from a word-addressed memory into one 256-bit result vector. A caller presents a base byte address, eight signed 32-bit indices, eight 32-bit mask elements, a passthrough vector and a scale factor, then pulses `start_i` for one cycle. Each lane whose mask element has its top bit set is treated as active. The block computes that lane's address and reads the element through a single-beat request/response memory port.

Lanes that are not active keep their passthrough element and cause no memory traffic. When every active lane has been filled, the block raises `done_o` for one cycle. The result and the error flag then stay on the outputs until the next accepted start. A scale outside the legal set aborts the operation with no reads: the result is the passthrough vector and the error flag is set.

Top module: `vgather_seq`

## Requirements
- R1: A lane is active exactly when bit 31 of its 32-bit mask element is 1. All other bits of the mask element have no effect.
- R2: The request address for lane i is the base plus the sign-extended 32-bit index of lane i times the scale, taken modulo 2^32.
- R3: `scale_i` carries the scale as a plain binary value. Only 1, 2, 4 and 8 are legal. Any other value makes the block issue no reads, return the passthrough vector unchanged and set `err_o`.
- R4: An inactive lane gets its passthrough element in the result and issues no memory read.
- R5: Lane i of the result holds the memory word read at lane i's address. Active lanes are requested in ascending lane order, with at most one read outstanding at any time.
- R6: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its address does not change.
- R7: `done_o` is high for exactly one cycle, on the cycle after the response for the last active lane is taken. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored. It changes neither the result nor the reads.
- R9: When no lane is active and the scale is legal, `done_o` rises on the cycle after the start edge and no read is issued.
- R10: `err_o` and `result_o` hold their values after `done_o` until the next accepted start. A start with a legal scale clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a gather |
| base_i | input | 32 | Base byte address |
| idx_i | input | 256 | Eight signed 32-bit indices, lane 0 in bits 31:0 |
| mask_i | input | 256 | Eight 32-bit mask elements, lane 0 in bits 31:0 |
| pass_i | input | 256 | Passthrough vector, lane 0 in bits 31:0 |
| scale_i | input | 4 | Scale value (legal: 1, 2, 4, 8) |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| busy_o | output | 1 | Gather in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last gather had an illegal scale |
| result_o | output | 256 | Assembled result vector |

## Verification
Random vectors mix mask elements whose only set bit is bit 31 with elements that have every bit except bit 31 set. This separates a sign-bit test from a non-zero test. Indices span both signs and values large enough to wrap the 32-bit address, and all four legal scales are used, so a wrong shift or a zero-extended index shows up as a wrong logged address. A random ready signal and random response latency test the request hold and the one-outstanding rule. Directed runs cover:
- a mask with no active lane;
- a mask with every lane active;
- illegal scales, followed by a legal run;
- a second start while the block is busy.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_REQ  = 2'd1,
        GS_WAIT = 2'd2,
        GS_FIN  = 2'd3
    } gs_state_e;
endpackage

// File: rtl/vgs_lane_pick.sv
module vgs_lane_pick #(
    parameter int LANES = 8,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend_i,
    output logic [LW-1:0]    lane_o,
    output logic             any_o
);
    always_comb begin
        lane_o = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (pend_i[k]) lane_o = LW'(k);
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/vgs_addr.sv
module vgs_addr #(
    parameter int AW = 32,
    parameter int EW = 32
) (
    input  logic [AW-1:0] base_i,
    input  logic [EW-1:0] idx_i,
    input  logic [1:0]    shift_i,
    output logic [AW-1:0] addr_o
);
    logic signed [AW-1:0] idx_ext;

    always_comb begin
        idx_ext = $signed(idx_i);
        addr_o  = base_i + (AW'(idx_ext) << shift_i);
    end
endmodule

// File: rtl/vgather_seq.sv
module vgather_seq #(
    parameter int LANES = 8,
    parameter int EW    = 32,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       base_i,
    input  logic [LANES*EW-1:0] idx_i,
    input  logic [LANES*EW-1:0] mask_i,
    input  logic [LANES*EW-1:0] pass_i,
    input  logic [3:0]          scale_i,
    output logic                mem_req_valid_o,
    input  logic                mem_req_ready_i,
    output logic [AW-1:0]       mem_req_addr_o,
    input  logic                mem_rsp_valid_i,
    input  logic [EW-1:0]       mem_rsp_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [LANES*EW-1:0] result_o
);
    import vgs_pkg::*;

    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int VW = LANES * EW;

    typedef struct packed {
        gs_state_e       st;
        logic [AW-1:0]   base;
        logic [VW-1:0]   idx;
        logic [VW-1:0]   res;
        logic [LANES-1:0] pend;
        logic [1:0]      sh;
        logic            err;
    } gs_regs_t;

    gs_regs_t r_d, r_q;

    logic [LANES-1:0] sign_w;
    logic [LW-1:0]    lane_w;
    logic             any_w;
    logic             scale_ok_w;
    logic [1:0]       scale_sh_w;

    for (genvar g = 0; g < LANES; g++) begin : g_sign
        assign sign_w[g] = mask_i[g*EW + EW - 1];
    end

    vgs_lane_pick #(.LANES(LANES), .LW(LW)) i_pick (
        .pend_i (r_q.pend),
        .lane_o (lane_w),
        .any_o  (any_w)
    );

    vgs_addr #(.AW(AW), .EW(EW)) i_addr (
        .base_i  (r_q.base),
        .idx_i   (r_q.idx[lane_w*EW +: EW]),
        .shift_i (r_q.sh),
        .addr_o  (mem_req_addr_o)
    );

    always_comb begin
        scale_ok_w = 1'b1;
        scale_sh_w = 2'd0;
        case (scale_i)
            4'd1:    scale_sh_w = 2'd0;
            4'd2:    scale_sh_w = 2'd1;
            4'd4:    scale_sh_w = 2'd2;
            4'd8:    scale_sh_w = 2'd3;
            default: scale_ok_w = 1'b0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            GS_IDLE: begin
                if (start_i) begin
                    r_d.base = base_i;
                    r_d.idx  = idx_i;
                    r_d.res  = pass_i;
                    r_d.sh   = scale_sh_w;
                    r_d.err  = !scale_ok_w;
                    r_d.pend = scale_ok_w ? sign_w : '0;
                    r_d.st   = (scale_ok_w && (|sign_w)) ? GS_REQ : GS_FIN;
                end
            end
            GS_REQ: begin
                if (mem_req_ready_i) r_d.st = GS_WAIT;
            end
            GS_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.res[lane_w*EW +: EW] = mem_rsp_data_i;
                    r_d.pend[lane_w]         = 1'b0;
                    r_d.st = (|r_d.pend) ? GS_REQ : GS_FIN;
                end
            end
            default: r_d.st = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req_valid_o = (r_q.st == GS_REQ);
    assign busy_o          = (r_q.st != GS_IDLE);
    assign done_o          = (r_q.st == GS_FIN);
    assign err_o           = r_q.err;
    assign result_o        = r_q.res;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

    // R4
    active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (any_w && r_q.pend[lane_w]));

    // R3
    err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && err_o) |-> !mem_req_valid_o);

    // R2
    scale8_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && r_q.sh == 2'd3) |-> (mem_req_addr_o[2:0] == r_q.base[2:0]));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && r_q.st == GS_REQ) |=> (r_q.st != GS_IDLE));
endmodule

// File: tb/test_vgather_seq.sv
module test_vgather_seq;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  base_i = '0;
    logic [255:0] idx_i = '0, mask_i = '0, pass_i = '0;
    logic [3:0]   scale_i = 4'd1;
    logic         mem_req_valid_o, mem_req_ready_i = 1'b0;
    logic [31:0]  mem_req_addr_o;
    logic         mem_rsp_valid_i = 1'b0;
    logic [31:0]  mem_rsp_data_i = '0;
    logic         busy_o, done_o, err_o;
    logic [255:0] result_o;

    vgather_seq i_vgather_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .idx_i(idx_i), .mask_i(mask_i), .pass_i(pass_i), .scale_i(scale_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .result_o(result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    int nlog = 0;
    logic [31:0] log_addr [0:15];
    int rsp_cnt = 0;
    logic [31:0] rsp_addr = '0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [31:0] ix,
                                             input logic [3:0] sc);
        return b + ix * {28'd0, sc};
    endfunction

    function automatic bit legal(input logic [3:0] sc);
        return sc == 4'd1 || sc == 4'd2 || sc == 4'd4 || sc == 4'd8;
    endfunction

    task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory model: drives away from the rising edge
    always @(negedge clk) begin
        mem_rsp_valid_i <= 1'b0;
        if (rsp_cnt > 0) begin
            if (rsp_cnt == 1) begin
                mem_rsp_valid_i <= 1'b1;
                mem_rsp_data_i  <= mem_word(rsp_addr);
            end
            rsp_cnt <= rsp_cnt - 1;
            mem_req_ready_i <= 1'b0;
        end else if (mem_rsp_valid_i) begin
            mem_req_ready_i <= 1'b0;
        end else begin
            automatic logic rdy = ($urandom % 3) != 0;
            mem_req_ready_i <= rdy;
            if (rdy && mem_req_valid_o) begin
                if (nlog < 16) log_addr[nlog] <= mem_req_addr_o;
                nlog     <= nlog + 1;
                rsp_addr <= mem_req_addr_o;
                rsp_cnt  <= 1 + int'($urandom % 3);
            end
        end
    end

    task automatic launch(input logic [31:0] b, input logic [255:0] ix, input logic [255:0] mk,
                          input logic [255:0] ps, input logic [3:0] sc);
        @(negedge clk);
        base_i = b; idx_i = ix; mask_i = mk; pass_i = ps; scale_i = sc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        nlog = 0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_o) chk("R7 timeout", 1'b0, 64'(cyc), 64'd0);
    endtask

    task automatic verify(input logic [31:0] b, input logic [255:0] ix, input logic [255:0] mk,
                          input logic [255:0] ps, input logic [3:0] sc);
        automatic int n_act = 0;
        automatic int k = 0;
        for (int l = 0; l < 8; l++) begin
            automatic bit act = legal(sc) && mk[l*32+31];
            automatic logic [31:0] a = exp_addr(b, ix[l*32 +: 32], sc);
            automatic logic [31:0] e = act ? mem_word(a) : ps[l*32 +: 32];
            chk(act ? "R5 lane data" : "R4 passthrough lane", result_o[l*32 +: 32] == e,
                64'(result_o[l*32 +: 32]), 64'(e));
            if (act) begin
                if (k < nlog && k < 16)
                    chk("R2 address order", log_addr[k] == a, 64'(log_addr[k]), 64'(a));
                k++;
                n_act++;
            end
        end
        chk("R1 read count", nlog == n_act, 64'(nlog), 64'(n_act));
        chk("R3 error flag", err_o == !legal(sc), 64'(err_o), 64'(!legal(sc)));
        chk("R7 busy with done", busy_o == 1'b1, 64'(busy_o), 64'd1);
    endtask

    task automatic run_one(input logic [31:0] b, input logic [255:0] ix, input logic [255:0] mk,
                           input logic [255:0] ps, input logic [3:0] sc);
        int cyc;
        launch(b, ix, mk, ps, sc);
        wait_done(cyc);
        verify(b, ix, mk, ps, sc);
        @(negedge clk);
        chk("R7 done one cycle", done_o == 1'b0, 64'(done_o), 64'd0);
    endtask

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int l = 0; l < 8; l++) v[l*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] rnd_mask();
        logic [255:0] v;
        for (int l = 0; l < 8; l++)
            v[l*32 +: 32] = ($urandom % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        return v;
    endfunction

    function automatic logic [255:0] rnd_idx();
        logic [255:0] v;
        for (int l = 0; l < 8; l++)
            v[l*32 +: 32] = ($urandom % 4 == 0) ? $urandom : 32'($signed(int'($urandom % 2001) - 1000));
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        automatic logic [3:0] scales [4] = '{4'd1, 4'd2, 4'd4, 4'd8};
        automatic logic [255:0] ps, ix, mk;
        int cyc;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R7 reset busy", busy_o == 1'b0, 64'(busy_o), 64'd0);
        chk("R7 reset done", done_o == 1'b0, 64'(done_o), 64'd0);
        chk("R6 reset request", mem_req_valid_o == 1'b0, 64'(mem_req_valid_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: no active lane (bits other than 31 set)
        ps = rnd_vec(); ix = rnd_idx();
        launch(32'h1000, ix, {8{32'h7FFF_FFFF}}, ps, 4'd4);
        chk("R9 done latency", done_o == 1'b1, 64'(done_o), 64'd1);
        verify(32'h1000, ix, {8{32'h7FFF_FFFF}}, ps, 4'd4);

        // every lane active
        run_one(32'h2000_0000, rnd_idx(), {8{32'h8000_0000}}, rnd_vec(), 4'd8);

        // R3: illegal scales, then R10: legal clears the flag
        run_one(32'h40, rnd_idx(), {8{32'hFFFF_FFFF}}, rnd_vec(), 4'd3);
        repeat (4) @(negedge clk);
        chk("R10 err held", err_o == 1'b1, 64'(err_o), 64'd1);
        run_one(32'h40, rnd_idx(), {8{32'hFFFF_FFFF}}, rnd_vec(), 4'd0);
        run_one(32'h40, rnd_idx(), rnd_mask(), rnd_vec(), 4'd2);
        chk("R10 err cleared", err_o == 1'b0, 64'(err_o), 64'd0);

        // R10: result held after done
        ps = result_o;
        repeat (5) @(negedge clk);
        chk("R10 result held", result_o == ps, 64'(result_o[63:0]), 64'(ps[63:0]));

        // R8: start while busy is ignored
        begin
            automatic logic [255:0] i8 = rnd_idx(), p8 = rnd_vec();
            launch(32'hFFFF_FF00, i8, {8{32'h8000_0000}}, p8, 4'd1);
            repeat (2) @(negedge clk);
            chk("R8 busy", busy_o == 1'b1, 64'(busy_o), 64'd1);
            base_i = 32'h0; idx_i = '0; mask_i = '0; scale_i = 4'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait_done(cyc);
            verify(32'hFFFF_FF00, i8, {8{32'h8000_0000}}, p8, 4'd1);
            @(negedge clk);
        end

        // random runs
        for (int t = 0; t < 60; t++) begin
            automatic logic [3:0] sc = ($urandom % 8 == 0) ? 4'($urandom % 16) : scales[$urandom % 4];
            run_one($urandom, rnd_idx(), rnd_mask(), rnd_vec(), sc);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule